// File: doc/BRIEF.md
# Indirect Register Port for a USB Host Controller

This block is the CPU-facing register slave of a USB host controller. The CPU sees only two 16-bit locations. It writes a register index to the address location, and then moves data through the data location. The top bit of the index sets the direction of the data transfers that follow it. The index range sets how wide the selected register is: low indices name 32-bit registers, which move as two 16-bit halves, low half first. Higher indices name 16-bit registers, which move in a single transfer.

Behind the port sit the following registers:
- a scratch word;
- a read-only identification word;
- a software-reset key location;
- an interrupt status register, whose bits are set by hardware event inputs and cleared by writing ones;
- an interrupt enable mask, reached through a set location and a clear location, whose bit 31 is a master enable.

A single level interrupt request is raised while the master enable is on and an enabled status bit is pending.

The port sequencing is a two-state machine:
- PH_LOW waits for a single 16-bit transfer or for the low half of a 32-bit transfer.
- PH_HIGH waits for the high half of a 32-bit transfer.

Its transitions are:
- "index load": any address write goes to PH_LOW.
- "low half taken": a data transfer in the chosen direction to a 32-bit index, while in PH_LOW, goes to PH_HIGH.
- "high half taken": a data transfer in the chosen direction while in PH_HIGH returns to PH_LOW.
- "narrow transfer": a data transfer to a 16-bit index stays in PH_LOW.

Top module: `hc_regport`

## Requirements
- R1: A write to the address location (bus_addr_sel=1) loads a 7-bit index from bus_wdata[6:0] and a direction flag from bus_wdata[7], where 1 means data writes and 0 means data reads. The load also returns the phase to PH_LOW.
- R2: Indices 0x00 to 0x1F are 32 bits wide. A data read returns bits [15:0] first and bits [31:16] second, on bus_rdata in the cycle after each read strobe.
- R3: A 32-bit register changes only when the high half of a write arrives. A low half that is followed by a new address write leaves the register unchanged.
- R4: Indices 0x20 and above are 16 bits wide and take exactly one data transfer each.
- R5: Index 0x27 reads as {8'h61, CHIP_REV}. Writes to it have no effect.
- R6: Index 0x28 is a 16-bit read/write scratch word that resets to zero.
- R7: Writing 0x00F6 to index 0x29 clears the scratch word, the status bits, the enable mask and the master enable. Any other value written there changes nothing, and index 0x29 reads as zero.
- R8: Writing ones to index 0x04 sets enable bits [NUM_EVT-1:0] and the master enable at bit 31. Writing ones to index 0x05 clears the same bits. Both indices read as {master, zeros, mask}.
- R9: Index 0x03 holds status bits [NUM_EVT-1:0]. A high hw_event bit sets its status bit, and writing a one clears it. When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: irq is high exactly when the master enable is set and at least one status bit is pending with its enable bit set.
- R11: Unmapped indices read as zero, and writes to them have no effect. A data write while in read mode, or a data read while in write mode, is ignored: no register changes and bus_rdata holds its value.
- R12: After reset, all registers are zero, bus_rdata is zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per transfer |
| bus_rd | input | 1 | Read strobe, one cycle per transfer |
| bus_addr_sel | input | 1 | 1 selects the address location, 0 selects the data location |
| bus_wdata | input | 16 | Write data or index with direction flag |
| bus_rdata | output | 16 | Read data, updated on each accepted data read |
| hw_event | input | NUM_EVT | Hardware interrupt event pulses |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sweeps every one of the 128 indices. A design that decoded the width boundary wrongly would lose or repeat a half, and one that aliased unmapped indices would return non-zero data there. It abandons a 32-bit write after its low half and then re-reads the register; a design that committed early would show the partial value. It lines up an event with a write-one-to-clear of the same bit in one cycle; a design that let the clear win would drop the pending bit. It also feeds transfers in the wrong direction and wrong software-reset keys, which a careless design would turn into register writes or resets.

// File: rtl/hc_regport_pkg.sv
package hc_regport_pkg;

    localparam int PORT_W = 16;
    localparam int IDX_W  = 7;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;

    localparam logic [IDX_W-1:0] IX_STAT    = 7'h03;
    localparam logic [IDX_W-1:0] IX_ENSET   = 7'h04;
    localparam logic [IDX_W-1:0] IX_ENCLR   = 7'h05;
    localparam logic [IDX_W-1:0] IX_CHIPID  = 7'h27;
    localparam logic [IDX_W-1:0] IX_SCRATCH = 7'h28;
    localparam logic [IDX_W-1:0] IX_SWRST   = 7'h29;
    localparam logic [IDX_W-1:0] WIDE_LIMIT = 7'h20;

    localparam logic [PORT_W-1:0] SWRST_KEY = 16'h00F6;
    localparam logic [7:0]        CHIPID_HI = 8'h61;

    function automatic logic is_wide(input logic [IDX_W-1:0] ix);
        return ix < WIDE_LIMIT;
    endfunction

endpackage

// File: rtl/hc_regport_seq.sv
module hc_regport_seq
    import hc_regport_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_wr,
    input  logic                acc_rd,
    input  logic                acc_addr,
    input  logic [PORT_W-1:0]   wdata,
    input  logic [2*PORT_W-1:0] rd_word,
    output logic [IDX_W-1:0]    idx,
    output logic                commit,
    output logic [2*PORT_W-1:0] commit_data,
    output logic [PORT_W-1:0]   rdata
);

    phase_t            phase_q, phase_d;
    logic              wr_mode_q;
    logic [IDX_W-1:0]  idx_q;
    logic [PORT_W-1:0] lo_q;
    logic [PORT_W-1:0] rdata_q;

    logic addr_load, data_wr, data_rd, xfer, wide;

    assign addr_load = acc_wr & acc_addr;
    assign data_wr   = acc_wr & ~acc_addr & wr_mode_q;
    assign data_rd   = acc_rd & ~acc_addr & ~wr_mode_q;
    assign xfer      = data_wr | data_rd;
    assign wide      = is_wide(idx_q);

    // next phase
    always_comb begin
        phase_d = phase_q;
        if (addr_load) begin
            phase_d = PH_LOW;
        end else begin
            unique case (phase_q)
                PH_LOW:  if (xfer && wide) phase_d = PH_HIGH;
                PH_HIGH: if (xfer)         phase_d = PH_LOW;
                default: phase_d = PH_LOW;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_LOW;
        else        phase_q <= phase_d;
    end

    // index, direction and staged low half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            wr_mode_q <= 1'b0;
            lo_q      <= '0;
        end else begin
            if (addr_load) begin
                idx_q     <= wdata[IDX_W-1:0];
                wr_mode_q <= wdata[7];
            end
            if (data_wr && wide && phase_q == PH_LOW) lo_q <= wdata;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (data_rd) begin
            rdata_q <= (phase_q == PH_HIGH) ? rd_word[2*PORT_W-1:PORT_W]
                                            : rd_word[PORT_W-1:0];
        end
    end

    assign commit      = data_wr & (~wide | (phase_q == PH_HIGH));
    assign commit_data = wide ? {wdata, lo_q} : {{PORT_W{1'b0}}, wdata};
    assign idx         = idx_q;
    assign rdata       = rdata_q;

    a_r1_addr_resets_phase: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> phase_q == PH_LOW);
    a_r2_wide_low_to_high: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && wide && phase_q == PH_LOW) |=> phase_q == PH_HIGH);
    a_r4_narrow_single: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !wide) |=> phase_q == PH_LOW);
    a_r11_wrong_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !acc_addr && wr_mode_q) |=> $stable(rdata_q));

endmodule

// File: rtl/hc_regport_irq.sv
module hc_regport_irq #(
    parameter int NUM_EVT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_clr,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               wr_stat,
    input  logic               wr_set,
    input  logic               wr_clr,
    input  logic [NUM_EVT-1:0] wbits,
    input  logic               wmaster,
    output logic [NUM_EVT-1:0] stat,
    output logic [NUM_EVT-1:0] mask,
    output logic               master,
    output logic               irq
);

    logic [NUM_EVT-1:0] stat_q, mask_q;
    logic               master_q;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   stat_q[i] <= 1'b0;
            else if (sw_clr)              stat_q[i] <= 1'b0;
            else if (evt[i])              stat_q[i] <= 1'b1;
            else if (wr_stat && wbits[i]) stat_q[i] <= 1'b0;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  mask_q[i] <= 1'b0;
            else if (sw_clr)             mask_q[i] <= 1'b0;
            else if (wr_set && wbits[i]) mask_q[i] <= 1'b1;
            else if (wr_clr && wbits[i]) mask_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 master_q <= 1'b0;
        else if (sw_clr)            master_q <= 1'b0;
        else if (wr_set && wmaster) master_q <= 1'b1;
        else if (wr_clr && wmaster) master_q <= 1'b0;
    end

    assign stat   = stat_q;
    assign mask   = mask_q;
    assign master = master_q;
    assign irq    = master_q & |(stat_q & mask_q);

    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_clr && evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));
    a_r7_swclr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> (stat_q == '0 && mask_q == '0 && !master_q));
    a_r8_set_reaches_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !sw_clr) |=> ((mask_q & $past(wbits)) == $past(wbits)));

endmodule

// File: rtl/hc_regport.sv
module hc_regport
    import hc_regport_pkg::*;
#(
    parameter int          NUM_EVT  = 7,
    parameter logic [7:0]  CHIP_REV = 8'h01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic               bus_addr_sel,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    input  logic [NUM_EVT-1:0] hw_event,
    output logic               irq
);

    localparam int WORD_W = 2 * PORT_W;
    localparam int PAD_W  = WORD_W - 1 - NUM_EVT;

    logic [IDX_W-1:0]   idx;
    logic               commit;
    logic [WORD_W-1:0]  commit_data;
    logic [WORD_W-1:0]  rd_word;
    logic [PORT_W-1:0]  scratch_q;
    logic [NUM_EVT-1:0] stat, mask;
    logic               master, sw_clr;
    logic               spare_unused;

    assign sw_clr = commit && idx == IX_SWRST && commit_data[PORT_W-1:0] == SWRST_KEY;
    assign spare_unused = ^commit_data[WORD_W-2:NUM_EVT];

    hc_regport_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_wr     (bus_wr),
        .acc_rd     (bus_rd),
        .acc_addr   (bus_addr_sel),
        .wdata      (bus_wdata),
        .rd_word    (rd_word),
        .idx        (idx),
        .commit     (commit),
        .commit_data(commit_data),
        .rdata      (bus_rdata)
    );

    hc_regport_irq #(.NUM_EVT(NUM_EVT)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_clr (sw_clr),
        .evt    (hw_event),
        .wr_stat(commit && idx == IX_STAT),
        .wr_set (commit && idx == IX_ENSET),
        .wr_clr (commit && idx == IX_ENCLR),
        .wbits  (commit_data[NUM_EVT-1:0]),
        .wmaster(commit_data[WORD_W-1]),
        .stat   (stat),
        .mask   (mask),
        .master (master),
        .irq    (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            scratch_q <= '0;
        else if (sw_clr)                       scratch_q <= '0;
        else if (commit && idx == IX_SCRATCH)  scratch_q <= commit_data[PORT_W-1:0];
    end

    always_comb begin
        rd_word = '0;
        case (idx)
            IX_STAT:             rd_word = {{(WORD_W-NUM_EVT){1'b0}}, stat};
            IX_ENSET, IX_ENCLR:  rd_word = {master, {PAD_W{1'b0}}, mask};
            IX_CHIPID:           rd_word = {{PORT_W{1'b0}}, CHIPID_HI, CHIP_REV};
            IX_SCRATCH:          rd_word = {{PORT_W{1'b0}}, scratch_q};
            default:             rd_word = '0;
        endcase
    end

    a_r6_scratch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !sw_clr) |=> $stable(scratch_q));
    a_r10_irq_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && !(commit && idx == IX_ENSET)) |=> !irq);

endmodule

// File: tb/hc_regport_bench.sv
module hc_regport_bench;

    localparam int         CLK_PERIOD = 10;
    localparam int         NE  = 7;
    localparam logic [7:0] REV = 8'h01;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_addr_sel = 1'b0;
    logic [15:0]   bus_wdata = '0;
    logic [15:0]   bus_rdata;
    logic [NE-1:0] hw_event = '0;
    logic          irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0]   m_scr = '0;
    logic [NE-1:0] m_stat = '0, m_mask = '0;
    logic          m_master = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hc_regport #(.NUM_EVT(NE), .CHIP_REV(REV)) u_hc_regport (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr_sel(bus_addr_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_event(hw_event), .irq(irq)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [6:0] ix);
        case (ix)
            7'h03:        return {{(32-NE){1'b0}}, m_stat};
            7'h04, 7'h05: return {m_master, {(31-NE){1'b0}}, m_mask};
            7'h27:        return {16'h0, 8'h61, REV};
            7'h28:        return {16'h0, m_scr};
            default:      return 32'h0;
        endcase
    endfunction

    task automatic addr_wr(input logic [7:0] a);
        @(negedge clk); bus_wr = 1; bus_addr_sel = 1; bus_wdata = {8'h0, a};
        @(negedge clk); bus_wr = 0; bus_addr_sel = 0;
    endtask

    task automatic data_wr(input logic [15:0] d);
        @(negedge clk); bus_wr = 1; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic data_rd(output logic [15:0] d);
        @(negedge clk); bus_rd = 1;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    task automatic reg_wr(input logic [6:0] ix, input logic [31:0] v);
        addr_wr({1'b1, ix});
        data_wr(v[15:0]);
        if (ix < 7'h20) data_wr(v[31:16]);
        case (ix)
            7'h03: m_stat &= ~v[NE-1:0];
            7'h04: begin m_mask |= v[NE-1:0];  m_master |= v[31];  end
            7'h05: begin m_mask &= ~v[NE-1:0]; if (v[31]) m_master = 0; end
            7'h28: m_scr = v[15:0];
            7'h29: if (v[15:0] == 16'h00F6) begin
                       m_scr = 0; m_stat = 0; m_mask = 0; m_master = 0;
                   end
            default: ;
        endcase
    endtask

    task automatic reg_rd(input logic [6:0] ix, output logic [31:0] v);
        logic [15:0] lo, hi;
        addr_wr({1'b0, ix});
        data_rd(lo);
        hi = 16'h0;
        if (ix < 7'h20) data_rd(hi);
        v = {hi, lo};
    endtask

    task automatic fire(input logic [NE-1:0] m);
        @(negedge clk); hw_event = m;
        @(negedge clk); hw_event = '0;
        m_stat |= m;
    endtask

    function automatic logic exp_irq();
        return m_master && ((m_stat & m_mask) != 0);
    endfunction

    task automatic check_mapped(input string tag);
        logic [31:0] v;
        for (int k = 0; k < 5; k++) begin
            logic [6:0] ix;
            ix = (k == 0) ? 7'h03 : (k == 1) ? 7'h04 : (k == 2) ? 7'h05 : (k == 3) ? 7'h27 : 7'h28;
            reg_rd(ix, v);
            chk($sformatf("%s idx %h", tag, ix), v, exp_rd(ix));
        end
        chk({tag, " irq"}, {31'h0, irq}, {31'h0, exp_irq()});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12: reset state
        chk("R12 rdata after reset", {16'h0, bus_rdata}, 32'h0);
        chk("R12 irq after reset", {31'h0, irq}, 32'h0);

        // R2 R4 R5 R11: sweep every index
        for (int ix = 0; ix < 128; ix++) begin
            reg_rd(ix[6:0], v);
            chk($sformatf("R2/R4/R11 sweep idx %h", ix), v, exp_rd(ix[6:0]));
        end

        // R6: scratch patterns
        for (int k = 0; k < 16; k++) begin
            logic [15:0] p;
            p = (16'h1 << k) ^ (16'(k) * 16'h0F0F);
            reg_wr(7'h28, {16'h0, p});
            reg_rd(7'h28, v);
            chk($sformatf("R6 scratch pattern %0d", k), v, {16'h0, p});
        end

        // R5: id is read-only
        reg_wr(7'h27, 32'h0000FFFF);
        reg_rd(7'h27, v);
        chk("R5 id after write", v, {16'h0, 8'h61, REV});

        // R3: abandoned low half
        addr_wr(8'h84);
        data_wr(16'h007F);
        reg_rd(7'h04, v);
        chk("R3 low half alone", v, exp_rd(7'h04));

        // R8: set then clear
        reg_wr(7'h04, 32'h8000007F);
        reg_rd(7'h04, v);
        chk("R8 enable set", v, 32'h8000007F);
        reg_wr(7'h05, 32'h00000005);
        reg_rd(7'h05, v);
        chk("R8 enable clear", v, 32'h8000007A);

        // R9 R10: each event bit
        for (int i = 0; i < NE; i++) begin
            fire(NE'(1) << i);
            reg_rd(7'h03, v);
            chk($sformatf("R9 status bit %0d set", i), v, exp_rd(7'h03));
            chk($sformatf("R10 irq bit %0d", i), {31'h0, irq}, {31'h0, exp_irq()});
            reg_wr(7'h03, 32'h1 << i);
            reg_rd(7'h03, v);
            chk($sformatf("R9 status bit %0d cleared", i), v, 32'h0);
            chk($sformatf("R10 irq low bit %0d", i), {31'h0, irq}, 32'h0);
        end

        // R10: master gate
        reg_wr(7'h05, 32'h80000000);
        fire('1);
        chk("R10 master off", {31'h0, irq}, 32'h0);
        reg_wr(7'h04, 32'h80000000);
        chk("R10 master on", {31'h0, irq}, 32'h1);

        // R9: event wins over clear in the same cycle
        addr_wr(8'h83);
        data_wr(16'hFFFF);
        @(negedge clk); bus_wr = 1; bus_wdata = 16'hFFFF; hw_event = 1;
        @(negedge clk); bus_wr = 0; hw_event = 0;
        m_stat = 1;
        reg_rd(7'h03, v);
        chk("R9 set beats clear", v, 32'h1);

        // R11 R7: ignored writes
        reg_wr(7'h10, 32'hFFFFFFFF);
        reg_wr(7'h30, 32'h0000FFFF);
        reg_wr(7'h29, 32'h00001234);
        reg_wr(7'h29, 32'h000000F7);
        check_mapped("R7/R11 ignored write");
        addr_wr(8'h28);
        data_wr(16'hBEEF);
        reg_rd(7'h28, v);
        chk("R11 write in read mode", v, exp_rd(7'h28));
        addr_wr(8'hA8);
        data_rd(d);
        chk("R11 read in write mode", {16'h0, d}, exp_rd(7'h28));

        // R7: key resets state
        reg_wr(7'h28, 32'h0000A5A5);
        reg_wr(7'h29, 32'h000000F6);
        check_mapped("R7 soft reset");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule